// File: doc/BRIEF.md
# 32-Pin GPIO Controller with Edge Event Capture

This block controls 32 general-purpose pins from a simple 32-bit register bus. Software chooses each pin's direction and drive type: push-pull or open-drain. It writes the output values and reads back the pin state. Input pins pass through a two-flop synchroniser. Their edges are then detected and stored in a per-pin event register. Software clears events by writing ones to that register. A per-pin mask gates the pending events onto one combined interrupt line. A per-pin sense bit chooses whether a pin reacts to both edges or to falling edges only.

The bus accepts a request in every cycle where `bus_en` is high, so there is no back-pressure. A write takes effect at the clock edge that samples it. A read returns its data one cycle later, marked by a one-cycle `bus_rvalid` pulse. The pad vectors are indexed by pin number. In every register, pin n occupies bit 31−n.

The word offsets are: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask, 0x14 sense.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, all six registers read as zero, `pad_oe` is zero (all pins are inputs) and `irq` is low.
- R2: Pin n (index n of `pad_in`, `pad_oe` and `pad_out`) corresponds to bit 31−n of every register, so pin 0 is bit 31.
- R3: A direction bit of 1 makes the pin an output. With its open-drain bit at 0, the pin has `pad_oe`=1 and `pad_out` equal to its data latch bit. A direction bit of 0 gives `pad_oe`=0.
- R4: An output pin whose open-drain bit is 1 is driven low (`pad_oe`=1, `pad_out`=0) when its data bit is 0, and is released (`pad_oe`=0) when its data bit is 1. `pad_out` is 0 for every open-drain pin.
- R5: Reading offset 0x08 returns the data latch bit for output pins and the synchronised pad value for input pins.
- R6: With a sense bit of 0, both rising and falling input edges set the pin's event bit. With a sense bit of 1, only falling edges set it.
- R7: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged.
- R8: `irq` is high exactly when some pin has both its event bit and its mask bit set. A mask bit of 1 enables that pin.
- R9: If an edge is detected on a pin in the same cycle that a write of 1 clears its event bit, the bit stays set.
- R10: A read returns data with `bus_rvalid` high on the cycle after the request, and for one cycle only. Offsets 0x18 to 0x1C read as zero.
- R11: A pad change that is applied between clock edges sets the event bit, and therefore raises `irq`, at the third rising edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Request strobe, always accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read request |
| bus_rdata | output | 32 | Read data |
| pad_in | input | 32 | Pad input values, indexed by pin |
| pad_oe | output | 32 | Pad output enable, indexed by pin |
| pad_out | output | 32 | Pad output value, indexed by pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong direction or open-drain state shows at once on `pad_oe` and `pad_out`. A wrong data latch or synchroniser state shows in the next read of the data register. A corrupted event register, or an event lost in the race between an edge and a clear, raises or drops `irq` in the same cycle when the mask is open. Otherwise it shows one cycle after a read of offset 0x0C. The edge latency is pinned to exactly three clock edges, so a synchroniser stage that is missing or added shows as an interrupt one cycle too early or too late.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int GPIO_PINS  = 32;
  localparam int GPIO_AW    = 5;
  localparam int GPIO_IDX_W = 3;

  // Word index = bus_addr[4:2]
  localparam logic [GPIO_IDX_W-1:0] IDX_DIR = 3'd0;
  localparam logic [GPIO_IDX_W-1:0] IDX_ODN = 3'd1;
  localparam logic [GPIO_IDX_W-1:0] IDX_DAT = 3'd2;
  localparam logic [GPIO_IDX_W-1:0] IDX_EVT = 3'd3;
  localparam logic [GPIO_IDX_W-1:0] IDX_MSK = 3'd4;
  localparam logic [GPIO_IDX_W-1:0] IDX_SNS = 3'd5;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr,
  output logic [W-1:0] ev_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise, fall, hit;

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
  assign hit  = fall | (rise & ~fall_only);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      ev_q   <= '0;
    end else begin
      prev_q <= level;
      // a fresh edge outranks a clear in the same cycle
      ev_q   <= (ev_q & ~clr) | hit;
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W  = GPIO_PINS,
  parameter int AW = GPIO_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  ev_q,
  input  logic [W-1:0]  pin_lvl,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  odn_q,
  output logic [W-1:0]  lat_q,
  output logic [W-1:0]  msk_q,
  output logic [W-1:0]  sns_q,
  output logic [W-1:0]  ev_clr,
  output logic          bus_rvalid,
  output logic [W-1:0]  bus_rdata
);
  logic [GPIO_IDX_W-1:0] idx;
  logic                  wr, rd;
  logic [W-1:0]          rd_mux;

  assign idx    = bus_addr[AW-1:2];
  assign wr     = bus_en & bus_we;
  assign rd     = bus_en & ~bus_we;
  assign ev_clr = (wr && idx == IDX_EVT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      odn_q <= '0;
      lat_q <= '0;
      msk_q <= '0;
      sns_q <= '0;
    end else if (wr) begin
      case (idx)
        IDX_DIR: dir_q <= bus_wdata;
        IDX_ODN: odn_q <= bus_wdata;
        IDX_DAT: lat_q <= bus_wdata;
        IDX_MSK: msk_q <= bus_wdata;
        IDX_SNS: sns_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IDX_DIR: rd_mux = dir_q;
      IDX_ODN: rd_mux = odn_q;
      IDX_DAT: rd_mux = (lat_q & dir_q) | (pin_lvl & ~dir_q);
      IDX_EVT: rd_mux = ev_q;
      IDX_MSK: rd_mux = msk_q;
      IDX_SNS: rd_mux = sns_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int W      = GPIO_PINS,
  parameter int AW     = GPIO_AW,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic          bus_rvalid,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_out,
  output logic          irq
);
  // Internal vectors use register order: pin n at bit W-1-n.
  logic [W-1:0] pad_in_r, sync_r, oe_r, out_r;
  logic [W-1:0] dir_q, odn_q, lat_q, msk_q, sns_q, ev_q, ev_clr;

  generate
    for (genvar p = 0; p < W; p++) begin : g_pin
      assign pad_in_r[W-1-p] = pad_in[p];
      assign pad_oe[p]       = oe_r[W-1-p];
      assign pad_out[p]      = out_r[W-1-p];
    end
  endgenerate

  gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in_r), .dout(sync_r)
  );

  gpio_edge #(.W(W)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(sync_r), .fall_only(sns_q),
    .clr(ev_clr), .ev_q(ev_q)
  );

  gpio_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ev_q(ev_q),
    .pin_lvl(sync_r), .dir_q(dir_q), .odn_q(odn_q), .lat_q(lat_q),
    .msk_q(msk_q), .sns_q(sns_q), .ev_clr(ev_clr),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
  );

  assign oe_r  = dir_q & ~(odn_q & lat_q);
  assign out_r = lat_q & ~odn_q;
  assign irq   = |(ev_q & msk_q);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int W  = GPIO_PINS,
  parameter int AW = GPIO_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_en,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rvalid,
  input logic [W-1:0]  oe_r,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  ev_q,
  input logic [W-1:0]  msk_q,
  input logic          irq
);
  logic evt_wr, dir_wr;
  assign evt_wr = bus_en && bus_we && (bus_addr[AW-1:2] == IDX_EVT);
  assign dir_wr = bus_en && bus_we && (bus_addr[AW-1:2] == IDX_DIR);

  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid); // R10
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> !bus_rvalid); // R10
  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_r & ~dir_q) == '0); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_q)); // R3
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr |=> ((ev_q & $past(ev_q)) == $past(ev_q))); // R7
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq); // R8
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .oe_r(oe_r),
  .dir_q(dir_q), .ev_q(ev_q), .msk_q(msk_q), .irq(irq)
);

// File: tb/gpio_ctrl_tb.sv
`timescale 1ns/100ps
module gpio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [31:0] pads = '0;
  logic [31:0] pad_oe, pad_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .pad_in(pads), .pad_oe(pad_oe),
    .pad_out(pad_out), .irq(irq)
  );

  localparam logic [4:0] A_DIR = 5'h00, A_ODN = 5'h04, A_DAT = 5'h08,
                         A_EVT = 5'h0C, A_MSK = 5'h10, A_SNS = 5'h14;

  // Vector table: dir, odn, data, pads -> read data, pad_oe, pad_out
  localparam int NV = 5;
  localparam logic [31:0] V_DIR [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'hFF00_0000};
  localparam logic [31:0] V_ODN [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hF000_0000};
  localparam logic [31:0] V_DAT [NV] = '{32'hFFFF_FFFF, 32'h1234_5678, 32'hAAAA_5555, 32'h0000_FFFF, 32'hA5FF_FFFF};
  localparam logic [31:0] V_PAD [NV] = '{32'h0000_0001, 32'h0000_0000, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic [31:0] V_RD  [NV] = '{32'h8000_0000, 32'h1234_5678, 32'hAAAA_FFFF, 32'h0000_FFFF, 32'hA500_0000};
  localparam logic [31:0] V_OE  [NV] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_00FA};
  localparam logic [31:0] V_OUT [NV] = '{32'hFFFF_FFFF, 32'h1E6A_2C48, 32'hAAAA_5555, 32'h0000_0000, 32'hFFFF_FFA0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    if (bus_rvalid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R10 rvalid actual=%b expected=1", bus_rvalid);
    end
    d = bus_rdata;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(A_DIR, d); chk("R1 dir", d, 32'h0);
    rd(A_ODN, d); chk("R1 odn", d, 32'h0);
    rd(A_DAT, d); chk("R1 data", d, 32'h0);
    rd(A_EVT, d); chk("R1 event", d, 32'h0);
    rd(A_MSK, d); chk("R1 mask", d, 32'h0);
    rd(A_SNS, d); chk("R1 sense", d, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 R3 R4 R5: vector table
    for (int v = 0; v < NV; v++) begin
      wr(A_DIR, V_DIR[v]);
      wr(A_ODN, V_ODN[v]);
      wr(A_DAT, V_DAT[v]);
      pads = V_PAD[v];
      idle(3);
      rd(A_DAT, d);
      chk($sformatf("R5 R2 readback v%0d", v), d, V_RD[v]);
      chk($sformatf("R3 R4 pad_oe v%0d", v), pad_oe, V_OE[v]);
      chk($sformatf("R3 R4 pad_out v%0d", v), pad_out, V_OUT[v]);
    end

    // back to a clean state for event tests
    wr(A_DIR, 32'h0); wr(A_ODN, 32'h0);
    pads = '0; idle(4);
    wr(A_EVT, 32'hFFFF_FFFF);
    rd(A_EVT, d); chk("R7 clear all", d, 32'h0);
    wr(A_MSK, 32'hFFFF_FFFF);

    // R11 latency, R6 rising with sense 0 (pin 5 -> bit 26)
    pads[5] = 1'b1;
    idle(2); chk("R11 irq before third edge", {31'h0, irq}, 32'h0);
    idle(1); chk("R11 irq at third edge", {31'h0, irq}, 32'h1);
    rd(A_EVT, d); chk("R6 rise sets event", d, 32'h0400_0000);

    // R7
    wr(A_EVT, 32'h0);
    rd(A_EVT, d); chk("R7 write 0 keeps event", d, 32'h0400_0000);
    wr(A_EVT, 32'h0400_0000);
    rd(A_EVT, d); chk("R7 write 1 clears", d, 32'h0);
    chk("R8 irq low after clear", {31'h0, irq}, 32'h0);

    // R6 falling with sense 0
    pads[5] = 1'b0; idle(3);
    rd(A_EVT, d); chk("R6 fall sets event sense0", d, 32'h0400_0000);
    wr(A_EVT, 32'h0400_0000);

    // R6 sense 1: falling only
    wr(A_SNS, 32'h0400_0000);
    pads[5] = 1'b1; idle(3);
    rd(A_EVT, d); chk("R6 rise ignored sense1", d, 32'h0);
    chk("R6 irq low on ignored rise", {31'h0, irq}, 32'h0);
    pads[5] = 1'b0; idle(3);
    rd(A_EVT, d); chk("R6 fall sets event sense1", d, 32'h0400_0000);

    // R8 mask gating
    wr(A_MSK, 32'h0000_0001);
    chk("R8 other pin masked", {31'h0, irq}, 32'h0);
    wr(A_MSK, 32'h0000_0000);
    chk("R8 all masked", {31'h0, irq}, 32'h0);
    wr(A_MSK, 32'h0400_0000);
    chk("R8 own mask open", {31'h0, irq}, 32'h1);
    wr(A_EVT, 32'h0400_0000);
    chk("R8 irq drops", {31'h0, irq}, 32'h0);

    // R9 edge and clear in the same cycle (pin 9 -> bit 22)
    pads[9] = 1'b1; idle(3);
    rd(A_EVT, d); chk("R9 setup event", d, 32'h0040_0000);
    pads[9] = 1'b0;
    idle(2);
    wr(A_EVT, 32'h0040_0000);   // sampled on the edge that sees the fall
    rd(A_EVT, d); chk("R9 edge wins over clear", d, 32'h0040_0000);
    wr(A_EVT, 32'h0040_0000);
    rd(A_EVT, d); chk("R9 later clear works", d, 32'h0);

    // R10 unmapped offset and single-cycle valid
    rd(5'h18, d); chk("R10 unmapped reads zero", d, 32'h0);
    @(negedge clk);
    chk("R10 rvalid one cycle", {31'h0, bus_rvalid}, 32'h0);
    rd(5'h1C, d); chk("R10 unmapped 0x1C", d, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule